// File: doc/BRIEF.md
# Timing-Speculative Pipeline Register with Shadow Check

This block is one pipeline register stage built to run with thin timing margins. A main register captures the incoming word at the start of each pipeline cycle, on the assumption that the logic in front of it has already settled. A second register, the shadow, captures the same input a fixed number of fast-clock ticks later. If the two captures differ in any bit, the main capture was taken too early. The stage then reports a timing error and rebuilds its output from the shadow copy.

The stage runs on a fast clock. A pipeline cycle lasts `CYCLE_TICKS` fast ticks, and `cycleStart` marks the tick that ends with the main capture edge. The shadow offset is `SHADOW_TICKS`. A path is captured correctly only if its delay lies between the shadow offset and the shadow offset plus one pipeline cycle. Paths shorter than the offset would corrupt the shadow copy, so the surrounding logic must respect a minimum delay.

When an error is found, the stage raises a one-cycle error pulse and requests recovery from the rest of the pipeline. By default it requests a one-cycle stall, so the upstream stage holds its data while the corrected word moves downstream. When `flushMode` is set, it requests a flush instead.

Top module: `tsr_stage`

## Requirements
- R1: While `rstN` is low, `qOut` and `errLanes` are zero and `errFlag`, `stallReq` and `flushReq` are low. The first fast tick after reset is released has `cycleStart` high.
- R2: `cycleStart` is high for exactly one fast tick in every `CYCLE_TICKS` ticks. `qOut` changes only at the rising edge at which `cycleStart` is high (the main edge).
- R3: If the input keeps one value from before the main edge until past the shadow edge, `qOut` shows that value after the main edge. No error follows at the next main edge.
- R4: If the shadow capture, taken `SHADOW_TICKS` ticks after a main edge, differs from the main capture, `errFlag` rises at the next main edge and stays high for exactly `CYCLE_TICKS` ticks.
- R5: At the main edge that raises `errFlag`, `qOut` takes the shadow value and ignores the current input.
- R6: With `flushMode` low at that main edge, `stallReq` is high for the same window as `errFlag` and `flushReq` stays low.
- R7: With `flushMode` high at that main edge, `flushReq` is high for the same window as `errFlag` and `stallReq` stays low.
- R8: `errLanes` holds the bitwise XOR of the main and shadow captures, registered together with `errFlag`. Bit i set means lane i mismatched. It is zero whenever `errFlag` is low.
- R9: A mismatch in one lane alone, including lane 0 or lane `WIDTH-1`, is enough to raise `errFlag`, because the flag is the OR of all lane mismatches.
- R10: After a correction, if the input holds the corrected value through the next shadow edge, the following main edge clears `errFlag` and the request, and `qOut` resumes following the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dIn | input | WIDTH | Data word from the logic in front of the stage |
| flushMode | input | 1 | 1 selects flush as the recovery request, 0 selects stall |
| qOut | output | WIDTH | Registered (and corrected) data word |
| cycleStart | output | 1 | High on the fast tick that ends with the main capture edge |
| errFlag | output | 1 | Timing error pulse, one pipeline cycle long |
| errLanes | output | WIDTH | Per-lane mismatch mask for the reported error |
| stallReq | output | 1 | One-cycle stall request in stall mode |
| flushReq | output | 1 | One-cycle flush request in flush mode |

## Verification
A steady input tells a clean capture apart from a false alarm. An input that changes between the main and shadow edges is the late-arrival case. A third value is driven just before the correction edge, which shows that the restored word comes from the shadow copy and not from the live input. Mismatches in the lowest lane alone, the highest lane alone, and many lanes at once separate the OR of lanes from any partial reduction and check the lane mask. Runs in both recovery modes, back to back, confirm that the request follows the mode and that each pulse lasts exactly one pipeline cycle.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  // Strobes sent from the control to the datapath each fast tick.
  typedef struct packed {
    logic mainEdge;    // this edge is the main (speculative) capture
    logic shadowEdge;  // this edge is the delayed shadow capture
    logic restore;     // main capture takes the shadow copy instead of the input
  } stageStrobes_t;

endpackage

// File: rtl/tsr_lane.sv
module tsr_lane
  import tsr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  stageStrobes_t strb,
  input  logic          dBit,
  output logic          qBit,
  output logic          mismatch
);

  logic mainQ;
  logic shadowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainQ   <= 1'b0;
      shadowQ <= 1'b0;
    end else begin
      if (strb.mainEdge) begin
        mainQ <= strb.restore ? shadowQ : dBit;
      end
      if (strb.shadowEdge) begin
        shadowQ <= dBit;
      end
    end
  end

  assign qBit     = mainQ;
  assign mismatch = mainQ ^ shadowQ;

endmodule

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobes_t    strb,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut,
  output logic [WIDTH-1:0] errLanes,
  output logic             anyMismatch
);

  logic [WIDTH-1:0] laneMismatch;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    tsr_lane lane_i (
      .clk      (clk),
      .rstN     (rstN),
      .strb     (strb),
      .dBit     (dIn[i]),
      .qBit     (qOut[i]),
      .mismatch (laneMismatch[i])
    );
  end

  assign anyMismatch = |laneMismatch;

  // Mask of failing lanes, reported for one pipeline cycle with the flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errLanes <= '0;
    end else if (strb.mainEdge) begin
      errLanes <= laneMismatch;
    end
  end

endmodule

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
#(
  parameter int CYCLE_TICKS  = 8,
  parameter int SHADOW_TICKS = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          anyMismatch,
  input  logic          flushMode,
  output stageStrobes_t strb,
  output logic          cycleStart,
  output logic          errFlag,
  output logic          stallReq,
  output logic          flushReq
);

  localparam int PHASE_W = (CYCLE_TICKS > 1) ? $clog2(CYCLE_TICKS) : 1;
  localparam logic [PHASE_W-1:0] LAST_PHASE   = PHASE_W'(CYCLE_TICKS - 1);
  localparam logic [PHASE_W-1:0] SHADOW_PHASE = PHASE_W'(SHADOW_TICKS);

  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (phase == LAST_PHASE) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strb.mainEdge   = (phase == '0);
    strb.shadowEdge = (phase == SHADOW_PHASE);
    strb.restore    = (phase == '0) && anyMismatch;
  end

  assign cycleStart = strb.mainEdge;

  // The flag and the request are decided at the main edge and held for one
  // pipeline cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      stallReq <= 1'b0;
      flushReq <= 1'b0;
    end else if (strb.mainEdge) begin
      errFlag  <= anyMismatch;
      stallReq <= anyMismatch && !flushMode;
      flushReq <= anyMismatch && flushMode;
    end
  end

endmodule

// File: rtl/tsr_stage.sv
module tsr_stage
  import tsr_pkg::*;
#(
  parameter int WIDTH        = 16,
  parameter int CYCLE_TICKS  = 8,
  parameter int SHADOW_TICKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  input  logic             flushMode,
  output logic [WIDTH-1:0] qOut,
  output logic             cycleStart,
  output logic             errFlag,
  output logic [WIDTH-1:0] errLanes,
  output logic             stallReq,
  output logic             flushReq
);

  stageStrobes_t strb;
  logic          anyMismatch;

  tsr_ctrl #(
    .CYCLE_TICKS  (CYCLE_TICKS),
    .SHADOW_TICKS (SHADOW_TICKS)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .anyMismatch (anyMismatch),
    .flushMode   (flushMode),
    .strb        (strb),
    .cycleStart  (cycleStart),
    .errFlag     (errFlag),
    .stallReq    (stallReq),
    .flushReq    (flushReq)
  );

  tsr_datapath #(
    .WIDTH (WIDTH)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dIn         (dIn),
    .qOut        (qOut),
    .errLanes    (errLanes),
    .anyMismatch (anyMismatch)
  );

endmodule

// File: rtl/tsr_stage_chk.sv
module tsr_stage_chk #(
  parameter int WIDTH       = 16,
  parameter int CYCLE_TICKS = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] qOut,
  input logic             cycleStart,
  input logic             errFlag,
  input logic [WIDTH-1:0] errLanes,
  input logic             stallReq,
  input logic             flushReq
);

  // Gap counter between main-edge ticks (R2).
  logic [31:0] gapCnt;
  logic        seenStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      seenStart <= 1'b0;
    end else if (cycleStart) begin
      gapCnt    <= '0;
      seenStart <= 1'b1;
    end else begin
      gapCnt <= gapCnt + 1;
    end
  end

  assert_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && seenStart) |-> (gapCnt == 32'(CYCLE_TICKS - 1)));

  assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cycleStart);

  assert_qout_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStart |=> $stable(qOut));

  assert_flag_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStart |=> $stable(errFlag));

  assert_one_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (stallReq != flushReq));

  assert_quiet_requests_R7: assert property (@(posedge clk) disable iff (!rstN)
    !errFlag |-> (!stallReq && !flushReq));

  assert_lanes_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (errLanes != '0));

  assert_lanes_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    !errFlag |-> (errLanes == '0));

endmodule

bind tsr_stage tsr_stage_chk #(
  .WIDTH       (WIDTH),
  .CYCLE_TICKS (CYCLE_TICKS)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .qOut       (qOut),
  .cycleStart (cycleStart),
  .errFlag    (errFlag),
  .errLanes   (errLanes),
  .stallReq   (stallReq),
  .flushReq   (flushReq)
);

// File: tb/tsr_stage_tb_top.sv
module tsr_stage_tb_top;

  localparam int W      = 16;
  localparam int CYC    = 8;
  localparam int SHADOW = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] dIn = '0;
  logic         flushMode = 1'b0;
  logic [W-1:0] qOut;
  logic         cycleStart;
  logic         errFlag;
  logic [W-1:0] errLanes;
  logic         stallReq;
  logic         flushReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  tsr_stage #(
    .WIDTH        (W),
    .CYCLE_TICKS  (CYC),
    .SHADOW_TICKS (SHADOW)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .dIn        (dIn),
    .flushMode  (flushMode),
    .qOut       (qOut),
    .cycleStart (cycleStart),
    .errFlag    (errFlag),
    .errLanes   (errLanes),
    .stallReq   (stallReq),
    .flushReq   (flushReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Move to the negedge just before the next main edge.
  task automatic toMainNext();
    do @(negedge clk); while (!cycleStart);
  endtask

  // One speculative capture: early value at the main edge, late value
  // arriving before the shadow edge. When junk is set, a third value is
  // driven just before the following main edge and the late value is put
  // back right after it (upstream holding during the stall).
  task automatic launch(input logic [W-1:0] early, input logic [W-1:0] late,
                        input logic fm, input bit junk, input string tag);
    toMainNext();
    dIn = early;
    flushMode = fm;
    @(negedge clk);
    check({tag, " R2 main capture"}, 32'(qOut), 32'(early));
    dIn = late;
    toMainNext();
    check({tag, " R4 no flag before edge"}, 32'(errFlag), 32'(0));
    if (junk) dIn = ~late;
    @(negedge clk);
    if (junk) dIn = late;
  endtask

  // Confirm the flag stays for the rest of the window and clears after (R4, R10).
  task automatic checkWindow(input string tag);
    for (int i = 1; i < CYC; i++) begin
      @(negedge clk);
      check({tag, " R4 flag held"}, 32'(errFlag), 32'(1));
    end
    @(negedge clk);
    check({tag, " R10 flag cleared"}, 32'(errFlag), 32'(0));
    check({tag, " R10 request cleared"}, 32'(stallReq | flushReq), 32'(0));
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 qOut in reset", 32'(qOut), 32'(0));
    check("R1 flags in reset", {29'd0, errFlag, stallReq, flushReq}, 32'(0));
    check("R1 lanes in reset", 32'(errLanes), 32'(0));
    rstN = 1'b1;
    check("R1 cycleStart after release", 32'(cycleStart), 32'(1));
  endtask

  task automatic testClean();
    launch(16'hA5C3, 16'hA5C3, 1'b0, 1'b0, "clean");
    check("R3 no error on stable input", 32'(errFlag), 32'(0));
    check("R3 qOut follows input", 32'(qOut), 32'(16'hA5C3));
    check("R3 no stall", 32'(stallReq), 32'(0));
  endtask

  task automatic testLateStall();
    launch(16'h1234, 16'h1F34, 1'b0, 1'b1, "stall");
    check("R4 flag raised", 32'(errFlag), 32'(1));
    check("R5 restored shadow value", 32'(qOut), 32'(16'h1F34));
    check("R6 stall requested", 32'(stallReq), 32'(1));
    check("R6 no flush", 32'(flushReq), 32'(0));
    check("R8 lane mask", 32'(errLanes), 32'(16'h1234 ^ 16'h1F34));
    checkWindow("stall");
    check("R10 qOut follows input", 32'(qOut), 32'(16'h1F34));
  endtask

  task automatic testLateFlush();
    launch(16'h00FF, 16'hFF00, 1'b1, 1'b1, "flush");
    check("R7 flag raised", 32'(errFlag), 32'(1));
    check("R7 flush requested", 32'(flushReq), 32'(1));
    check("R7 no stall", 32'(stallReq), 32'(0));
    check("R5 restored shadow value", 32'(qOut), 32'(16'hFF00));
    check("R8 lane mask all", 32'(errLanes), 32'(16'hFFFF));
    checkWindow("flush");
    flushMode = 1'b0;
  endtask

  task automatic testSingleLanes();
    launch(16'h0000, 16'h0001, 1'b0, 1'b0, "lsb");
    check("R9 lane 0 alone flags", 32'(errFlag), 32'(1));
    check("R9 lane 0 mask", 32'(errLanes), 32'(16'h0001));
    check("R5 lane 0 corrected", 32'(qOut), 32'(16'h0001));
    launch(16'h7FFF, 16'hFFFF, 1'b0, 1'b0, "msb");
    check("R9 top lane alone flags", 32'(errFlag), 32'(1));
    check("R9 top lane mask", 32'(errLanes), 32'(16'h8000));
    check("R5 top lane corrected", 32'(qOut), 32'(16'hFFFF));
    checkWindow("msb");
  endtask

  task automatic testBackToBack();
    launch(16'hCAFE, 16'hBEEF, 1'b0, 1'b1, "b2b first");
    check("R6 first stall", 32'(stallReq), 32'(1));
    // Next cycle's shadow sees another late change, so the next edge flags again.
    @(negedge clk);
    dIn = 16'hBEEE;
    toMainNext();
    @(negedge clk);
    check("R4 second flag", 32'(errFlag), 32'(1));
    check("R5 second correction", 32'(qOut), 32'(16'hBEEE));
    check("R8 second mask", 32'(errLanes), 32'(16'h0001));
    checkWindow("b2b second");
  endtask

  initial begin
    testReset();
    testClean();
    testLateStall();
    testLateFlush();
    testSingleLanes();
    testBackToBack();
    testClean();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %h expected %h", 32'(0), 32'(1));
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule